// File: doc/BRIEF.md
# Sparse Chunk Head Searcher

This block resolves one level of a compressed longest-prefix trie when the chunk for that level is stored in sparse form. A sparse chunk keeps between one and eight 8-bit head values, sorted from largest to smallest, each paired with a 16-bit result pointer. Given the address byte for the current level, the block returns the pointer paired with the first head whose value does not exceed that byte.

The searcher reads the chunk through a single synchronous read port. Word offset `i` (0 to 7) above the chunk base holds head `i` in its low byte. Word offset `8 + i` holds pointer `i`. Read data is valid in the cycle after `mem_rd` is raised.

When the chunk has at least four heads, the searcher first reads head 3. That one comparison selects either heads 0..3 or heads 4 onward, and only the selected half is then scanned in order. This bounds a search to five head reads and one pointer read. A search starts with a one-cycle `start`, and its result is announced by a one-cycle `done`. The reset input is taken as already released in step with the clock.

Top module: `sparse_chunk_search`

## Requirements
- R1: While reset is asserted, `done`, `mem_rd` and `err` are 0 and `ptr` is all zeros.
- R2: When a match exists, `ptr` carries the word read at offset 8+i, where i is the lowest position below the effective count whose head (low byte of the word at offset i) is less than or equal to `key`; `err` is 0.
- R3: With an effective count of 4 or more, the first read of a search is at offset 3. With an effective count of 1 to 3, the first read is at offset 0.
- R4: The effective count is `head_cnt`, with values above 8 treated as 8. No head read of a search is at an offset equal to or above the effective count.
- R5: A search makes at most five head reads and at most one pointer read.
- R6: When no position below the effective count matches, `err` is 1, `ptr` is all zeros and no pointer read is made. An effective count of 0 gives this result with no reads at all.
- R7: `done` is high for exactly one cycle per search (unless a new search is started in that cycle). `ptr` and `err` keep their values until the next accepted start.
- R8: A `start` raised while a search is in progress is ignored, and the running search returns its own result.
- R9: A `start` raised in the same cycle as `done` is accepted, so searches may run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled when idle or when `done` is high |
| key | input | 8 | Address byte for this trie level |
| head_cnt | input | 4 | Number of valid heads in the chunk |
| chunk_base | input | 8 | Word address of the chunk's first word |
| mem_rd | output | 1 | Read strobe to chunk memory |
| mem_addr | output | 8 | Word address of the read |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| ptr | output | 16 | Pointer paired with the matching head |
| done | output | 1 | Result valid strobe |
| err | output | 1 | No head at or below the key |

## Verification
Two functions can fall in the same cycle: the completion strobe of one search and the acceptance of the next. The bench provokes this by raising `start` with a fresh chunk as soon as it sees `done` high, so the new start is in place at the clock edge that would otherwise return the block to idle. It then judges that the second search returns its own pointer and makes its own probe read. A second overlap is also tested: a `start` carrying a different key and count arrives while a search is mid-scan. The bench checks that the first search's result and read pattern are unaffected.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE_RD,
    ST_PROBE_CHK,
    ST_SCAN_RD,
    ST_SCAN_CHK,
    ST_PTR_RD,
    ST_PTR_CHK,
    ST_DONE
  } sps_state_e;

endpackage

// File: rtl/sps_cmp.sv
module sps_cmp #(
  parameter int KW = 8
) (
  input  logic [KW-1:0] head,
  input  logic [KW-1:0] key,
  output logic          hit
);

  always_comb begin
    hit = (head <= key);
  end

endmodule

// File: rtl/sps_agen.sv
module sps_agen #(
  parameter int AW = 8,
  parameter int NH = 8,
  localparam int CW = $clog2(NH + 1)
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] idx,
  input  logic          sel_ptr,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] PTR_OFS = AW'(NH);

  logic [AW-1:0] offset;

  always_comb begin
    offset = sel_ptr ? (PTR_OFS + AW'(idx)) : AW'(idx);
    addr   = base + offset;
  end

endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
#(
  parameter int AW = 8,
  parameter int KW = 8,
  parameter int PW = 16,
  parameter int NH = 8,
  localparam int CW = $clog2(NH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] key,
  input  logic [CW-1:0] head_cnt,
  input  logic [AW-1:0] chunk_base,
  input  logic [PW-1:0] mem_rdata,
  input  logic          hit,
  output logic [KW-1:0] key_q,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] idx,
  output logic          rd,
  output logic          sel_ptr,
  output logic [PW-1:0] ptr,
  output logic          done,
  output logic          err
);

  localparam int            HALF    = NH / 2;
  localparam logic [CW-1:0] NH_C    = CW'(NH);
  localparam logic [CW-1:0] HALF_C  = CW'(HALF);
  localparam logic [CW-1:0] PROBE_C = CW'(HALF - 1);
  localparam int            SW      = CW + 1;

  sps_state_e    state_q, state_d;
  logic [KW-1:0] key_d;
  logic [AW-1:0] base_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_in;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [CW-1:0] idx_inc;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          err_q, err_d;
  logic          accept, busy, reg_en;

  always_comb begin
    cnt_in  = (head_cnt > NH_C) ? NH_C : head_cnt;
    accept  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
    reg_en  = accept || (state_q != ST_IDLE);
    idx_inc = CW'(idx_q + 1'b1);
  end

  always_comb begin
    state_d = state_q;
    key_d   = key_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    lim_d   = lim_q;
    ptr_d   = ptr_q;
    err_d   = err_q;
    rd      = 1'b0;
    sel_ptr = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          key_d  = key;
          base_d = chunk_base;
          cnt_d  = cnt_in;
          ptr_d  = '0;
          err_d  = 1'b0;
          if (cnt_in == '0) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else if (cnt_in >= HALF_C) begin
            idx_d   = PROBE_C;
            state_d = ST_PROBE_RD;
          end else begin
            idx_d   = '0;
            lim_d   = cnt_in;
            state_d = ST_SCAN_RD;
          end
        end else if (state_q == ST_DONE) begin
          state_d = ST_IDLE;
        end
      end
      ST_PROBE_RD: begin
        rd      = 1'b1;
        state_d = ST_PROBE_CHK;
      end
      ST_PROBE_CHK: begin
        if (hit) begin
          idx_d   = '0;
          lim_d   = HALF_C;
          state_d = ST_SCAN_RD;
        end else begin
          idx_d = HALF_C;
          lim_d = cnt_q;
          if (HALF_C < cnt_q) begin
            state_d = ST_SCAN_RD;
          end else begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_SCAN_RD: begin
        rd      = 1'b1;
        state_d = ST_SCAN_CHK;
      end
      ST_SCAN_CHK: begin
        if (hit) begin
          state_d = ST_PTR_RD;
        end else if (idx_inc >= lim_q) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          idx_d   = idx_inc;
          state_d = ST_SCAN_RD;
        end
      end
      ST_PTR_RD: begin
        rd      = 1'b1;
        sel_ptr = 1'b1;
        state_d = ST_PTR_CHK;
      end
      ST_PTR_CHK: begin
        ptr_d   = mem_rdata;
        state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      lim_q   <= '0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      key_q   <= key_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      lim_q   <= lim_d;
      ptr_q   <= ptr_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    idx  = idx_q;
    ptr  = ptr_q;
    err  = err_q;
    done = (state_q == ST_DONE);
  end

  logic [SW-1:0] heads_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heads_seen <= '0;
    end else if (accept) begin
      heads_seen <= '0;
    end else if (rd && !sel_ptr) begin
      heads_seen <= SW'(heads_seen + 1'b1);
    end
  end

  // R4
  head_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !sel_ptr) |-> (idx_q < cnt_q));

  // R5
  head_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    heads_seen <= SW'(HALF + 1));

  // R6
  err_no_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_q) |-> (ptr_q == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R3
  probe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cnt_in >= HALF_C)) |=> (rd && !sel_ptr && (idx_q == PROBE_C)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(key_q) && $stable(base_q) && $stable(cnt_q)));

endmodule

// File: rtl/sparse_chunk_search.sv
module sparse_chunk_search #(
  parameter int AW = 8,
  parameter int KW = 8,
  parameter int PW = 16,
  parameter int NH = 8,
  localparam int CW = $clog2(NH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] key,
  input  logic [CW-1:0] head_cnt,
  input  logic [AW-1:0] chunk_base,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [PW-1:0] mem_rdata,
  output logic [PW-1:0] ptr,
  output logic          done,
  output logic          err
);

  logic [KW-1:0] key_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] idx;
  logic          sel_ptr;
  logic          hit;

  sps_ctrl #(.AW(AW), .KW(KW), .PW(PW), .NH(NH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .key        (key),
    .head_cnt   (head_cnt),
    .chunk_base (chunk_base),
    .mem_rdata  (mem_rdata),
    .hit        (hit),
    .key_q      (key_q),
    .base_q     (base_q),
    .idx        (idx),
    .rd         (mem_rd),
    .sel_ptr    (sel_ptr),
    .ptr        (ptr),
    .done       (done),
    .err        (err)
  );

  sps_cmp #(.KW(KW)) u_cmp (
    .head (mem_rdata[KW-1:0]),
    .key  (key_q),
    .hit  (hit)
  );

  sps_agen #(.AW(AW), .NH(NH)) u_agen (
    .base    (base_q),
    .idx     (idx),
    .sel_ptr (sel_ptr),
    .addr    (mem_addr)
  );

endmodule

// File: tb/tb_sparse_chunk_search.sv
module tb_sparse_chunk_search;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  key;
  logic [3:0]  head_cnt;
  logic [7:0]  chunk_base;
  logic        mem_rd;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] ptr;
  logic        done;
  logic        err;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;

  logic [15:0] mem [256];

  sparse_chunk_search dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .key        (key),
    .head_cnt   (head_cnt),
    .chunk_base (chunk_base),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .ptr        (ptr),
    .done       (done),
    .err        (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // read monitor
  int         n_head, n_ptr, first_off, max_head;
  logic [7:0] mon_base;

  always @(posedge clk) begin
    if (rst_n && mem_rd) begin
      automatic logic [7:0] off = mem_addr - mon_base;
      if (first_off < 0) first_off = int'(off);
      if (off < 8) begin
        n_head++;
        if (int'(off) > max_head) max_head = int'(off);
      end else begin
        n_ptr++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] c);
    return (c > 4'd8) ? 8 : int'(c);
  endfunction

  function automatic int ref_idx(input logic [7:0] b, input logic [7:0] k, input logic [3:0] c);
    for (int i = 0; i < eff(c); i++) begin
      if (mem[8'(b + 8'(i))][7:0] <= k) return i;
    end
    return -1;
  endfunction

  // heads strictly decreasing; garbage beyond the count
  task automatic fill(input logic [7:0] b, input int ce, input bit zero_tail);
    int h;
    h = zero_tail ? 0 : 1 + int'($urandom % 20);
    for (int i = 7; i >= 0; i--) begin
      mem[8'(b + 8'(i + 8))] = 16'($urandom);
      if (i < ce) begin
        mem[8'(b + 8'(i))] = {8'($urandom), 8'(h)};
        h = h + 1 + int'($urandom % 20);
      end else begin
        mem[8'(b + 8'(i))] = 16'($urandom);
      end
    end
  endtask

  task automatic mon_clear(input logic [7:0] b);
    n_head = 0; n_ptr = 0; first_off = -1; max_head = -1; mon_base = b;
  endtask

  task automatic issue(input logic [7:0] k, input logic [3:0] c, input logic [7:0] b);
    start = 1'b1; key = k; head_cnt = c; chunk_base = b;
    mon_clear(b);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk(1'b0, "R7 done timeout", 0, 1);
  endtask

  task automatic judge(input logic [7:0] k, input logic [3:0] c, input logic [7:0] b);
    int ix, ce;
    ix = ref_idx(b, k, c);
    ce = eff(c);
    if (ix >= 0) begin
      chk(ptr == mem[8'(b + 8'(ix + 8))], "R2 ptr", int'(ptr), int'(mem[8'(b + 8'(ix + 8))]));
      chk(err == 1'b0, "R2 err", int'(err), 0);
      chk(n_ptr == 1, "R5 ptr reads", n_ptr, 1);
    end else begin
      chk(err == 1'b1, "R6 err", int'(err), 1);
      chk(ptr == 16'h0, "R6 ptr", int'(ptr), 0);
      chk(n_ptr == 0, "R6 no ptr read", n_ptr, 0);
    end
    if (ce == 0) chk(n_head == 0, "R6 no reads", n_head, 0);
    else chk(first_off == ((ce >= 4) ? 3 : 0), "R3 first read", first_off, (ce >= 4) ? 3 : 0);
    chk(max_head < ce, "R4 head range", max_head, ce - 1);
    chk(n_head <= 5, "R5 head reads", n_head, 5);
  endtask

  task automatic search(input logic [7:0] k, input logic [3:0] c, input logic [7:0] b);
    bit ok;
    issue(k, c, b);
    wait_done(ok);
    if (ok) judge(k, c, b);
    @(negedge clk);
  endtask

  initial begin
    bit ok;
    logic [15:0] hold;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    rst_n = 1'b0; start = 1'b0; key = '0; head_cnt = '0; chunk_base = '0;
    mon_clear(8'h0);
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(mem_rd == 1'b0, "R1 mem_rd", int'(mem_rd), 0);
    chk(err == 1'b0, "R1 err", int'(err), 0);
    chk(ptr == 16'h0, "R1 ptr", int'(ptr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    fill(8'h10, 8, 1'b1);
    search(8'hFF, 4'd8, 8'h10);          // R2 match at head 0
    search(8'h00, 4'd8, 8'h10);          // R2 match at last head 0
    fill(8'h20, 4, 1'b0);
    search(8'h00, 4'd4, 8'h20);          // R6 probe misses, upper half empty
    fill(8'h30, 3, 1'b1);
    search(8'h05, 4'd3, 8'h30);          // R3 no probe below four heads
    fill(8'h40, 1, 1'b1);
    search(8'h80, 4'd1, 8'h40);          // R3 single head
    search(8'h80, 4'd0, 8'h40);          // R6 count zero
    fill(8'h50, 8, 1'b0);
    search(8'h00, 4'd13, 8'h50);         // R4 count clamped, R6 no match
    search(mem[8'h53][7:0], 4'd12, 8'h50); // R4 clamp, match at probe head

    // R7 hold after done
    fill(8'h60, 6, 1'b1);
    issue(8'h20, 4'd6, 8'h60);
    wait_done(ok);
    if (ok) begin
      judge(8'h20, 4'd6, 8'h60);
      hold = ptr;
      @(negedge clk);
      chk(done == 1'b0, "R7 pulse", int'(done), 0);
      @(negedge clk);
      chk(ptr == hold, "R7 hold", int'(ptr), int'(hold));
    end

    // R8 start while busy ignored
    fill(8'h70, 7, 1'b1);
    fill(8'h80, 2, 1'b1);
    issue(8'h30, 4'd7, 8'h70);
    start = 1'b1; key = 8'h00; head_cnt = 4'd2; chunk_base = 8'h80;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) judge(8'h30, 4'd7, 8'h70);  // R8
    @(negedge clk);

    // R9 back-to-back start in the done cycle
    for (int t = 0; t < 10; t++) begin
      automatic logic [7:0] ka = 8'($urandom);
      automatic logic [7:0] kb = 8'($urandom);
      automatic logic [3:0] cb = 4'(1 + $urandom % 8);
      fill(8'h90, 8, 1'b1);
      fill(8'hA0, eff(cb), 1'b1);
      issue(ka, 4'd8, 8'h90);
      wait_done(ok);
      if (ok) begin
        judge(ka, 4'd8, 8'h90);
        issue(kb, cb, 8'hA0);         // R9 raised while done is high
        chk(done == 1'b0, "R9 accepted", int'(done), 0);
        wait_done(ok);
        if (ok) judge(kb, cb, 8'hA0);  // R9
      end
      @(negedge clk);
    end

    // random searches
    for (int t = 0; t < 300; t++) begin
      automatic logic [7:0] b = 8'(($urandom % 16) * 16);
      automatic logic [3:0] c = 4'($urandom % 16);
      automatic logic [7:0] k = 8'($urandom);
      fill(b, eff(c), ($urandom % 4) != 0);
      if (($urandom % 3) == 0 && eff(c) > 0)
        k = mem[8'(b + 8'($urandom % eff(c)))][7:0];
      search(k, c, b);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule